// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block switches a set of on-chip power domains up and down in a fixed, asymmetric order. For each domain it drives the following outputs:

- a power-switch sleep bit
- an isolation bit
- a group of 2-bit memory power-down fields
- a domain reset
- a clock enable

The order keeps logic isolated until its supply and memories are stable. It also keeps the clock off until reset has been released. Each domain's capabilities are set by parameter masks: it may have a top switch (sleep and isolation), a reset and a clock. A domain without a top switch is memory-only.

Software-side logic hands the block one command at a time on a valid/ready request channel. A command carries a domain index and an on/off flag, with flag 1 meaning power on. `req_ready_o` is high only while the sequencer is idle, and a command is taken on a rising edge where valid and ready are both high. While a sequence runs, ready stays low, so a requester has to hold its command, and anything offered in that time is not taken. On completion, `done_o` pulses for one cycle. `err_o` goes high with that pulse when the index was out of range.

All waits come from one shared down-counter. The short gap is `CYC_PER_US*SHORT_US` cycles, written U. The long clock-gating gap is `CYC_PER_US*LONG_US` cycles, written L.

Top module: `pwr_dom_seq`

## Requirements
- R1: A power-on command moves through its steps in this order:
  1. Sleep clears at accept edge +1.
  2. The domain's memory fields clear at edge +2+U.
  3. Reset is asserted, isolation clears, then reset is released.
  4. The clock enable rises.
  5. `done_o` is high in the cycle beginning at edge +6+2U.
- R2: A power-off command on a domain without a clock proceeds as follows:
  1. Sleep is set at accept edge +1.
  2. The domain's memory fields are set at edge +2+U.
  3. Isolation is set at edge +3+2U.
  4. `done_o` is high in the cycle beginning at edge +3+2U.
- R3: A power-off command on a domain with a clock follows R2, then waits L cycles after isolation and gates the clock. `done_o` is then high in the cycle beginning at edge +4+2U+L, with `clk_en_o` low.
- R4: A memory-only domain keeps its sleep and isolation bits at 1 forever. Its commands change only its memory fields, and they keep the same step timing.
- R5: A domain without a reset keeps its `rst_o` bit at 1. A domain without a clock keeps its `clk_en_o` bit at 0. In both cases the step timing is unchanged.
- R6: Domain d owns `mem_pd_o[d*2*FIELDS +: 2*FIELDS]`. Bits are grouped in pairs (2k, 2k+1) that always hold the same value: all 1 means powered down and all 0 means powered up. A command changes no other domain's bits.
- R7: `powered_o[d]` is the inverse of the sleep bit for a domain with a top switch. For a memory-only domain it is 1 exactly when all of its memory bits are 0.
- R8: A command whose index is not below `N_DOM` is accepted. `done_o` and `err_o` are then both high in the cycle beginning at the accept edge, and no domain output changes.
- R9: `req_ready_o` is high only when idle. A request offered while busy is ignored. `done_o` is high for exactly one cycle, and ready returns in the following cycle.
- R10: After reset, every sleep, isolation, memory and reset bit is 1, every clock enable is 0, `req_ready_o` is 1 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Command offered |
| req_ready_o | output | 1 | Sequencer idle, command taken when valid is also high |
| req_dom_i | input | IDX_W | Domain index of the command |
| req_on_i | input | 1 | 1 = power on, 0 = power off |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With done_o: index was out of range |
| sleep_o | output | N_DOM | Power-switch sleep bit per domain, 1 = off |
| iso_o | output | N_DOM | Isolation bit per domain, 1 = isolated |
| mem_pd_o | output | N_DOM*2*FIELDS | Memory power-down fields, 1 = powered down |
| rst_o | output | N_DOM | Domain reset, 1 = asserted |
| clk_en_o | output | N_DOM | Domain clock enable |
| powered_o | output | N_DOM | Domain powered status |

## Verification
Every result is tied to a cycle offset from the accepting edge:

- sleep at +1;
- the memory fields still unchanged at +1+U and switched at +2+U;
- completion at +6+2U, +3+2U or +4+2U+L, depending on direction and clock ownership;
- completion for an out-of-range command in the cycle right after acceptance.

The bench counts rising edges from that edge and samples on the falling edge that follows the offset, so each check lands in the cycle the requirement names. Final vectors and the one-cycle done pulse are compared against a per-domain model in the bench. That comparison is made once the pulse is seen.

// File: rtl/pwr_dom_seq_pkg.sv
package pwr_dom_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SLEEP,
    ST_WAIT_A,
    ST_MEM,
    ST_WAIT_B,
    ST_RST_SET,
    ST_ISO,
    ST_RST_CLR,
    ST_CLK_ON,
    ST_WAIT_LONG,
    ST_CLK_OFF,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic sleep;
    logic mem;
    logic rst_set;
    logic iso;
    logic rst_clr;
    logic clk_on;
    logic clk_off;
  } step_t;

endpackage

// File: rtl/pwr_dom_seq_timer.sv
module pwr_dom_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwr_dom_seq_fsm.sv
module pwr_dom_seq_fsm
  import pwr_dom_seq_pkg::*;
#(
  parameter int               N_DOM     = 4,
  parameter int               IDX_W     = 3,
  parameter int               SEL_W     = 2,
  parameter int               CNT_W     = 8,
  parameter int               SHORT_CYC = 20,
  parameter int               LONG_CYC  = 200,
  parameter logic [N_DOM-1:0] HAS_CLK   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_dom,
  input  logic             req_on,
  input  logic             expired,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output step_t            step,
  output logic [SEL_W-1:0] sel,
  output logic             on_dir,
  output logic             done,
  output logic             err
);

  seq_state_e       state_q, state_d;
  logic [SEL_W-1:0] sel_q;
  logic             on_q;
  logic             err_q;
  logic             in_range;
  logic             accept;

  assign in_range = (32'(req_dom) < N_DOM);
  assign accept   = (state_q == ST_IDLE) && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      on_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sel_q <= req_dom[SEL_W-1:0];
        on_q  <= req_on;
        err_q <= ~in_range;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = CNT_W'(SHORT_CYC - 1);
    unique case (state_q)
      ST_IDLE:      if (req_valid) state_d = in_range ? ST_SLEEP : ST_FIN;
      ST_SLEEP: begin
        t_load  = 1'b1;
        state_d = ST_WAIT_A;
      end
      ST_WAIT_A:    if (expired) state_d = ST_MEM;
      ST_MEM: begin
        t_load  = 1'b1;
        state_d = ST_WAIT_B;
      end
      ST_WAIT_B:    if (expired) state_d = on_q ? ST_RST_SET : ST_ISO;
      ST_RST_SET:   state_d = ST_ISO;
      ST_ISO: begin
        if (on_q) begin
          state_d = ST_RST_CLR;
        end else if (HAS_CLK[sel_q]) begin
          t_load  = 1'b1;
          t_val   = CNT_W'(LONG_CYC - 1);
          state_d = ST_WAIT_LONG;
        end else begin
          state_d = ST_FIN;
        end
      end
      ST_RST_CLR:   state_d = ST_CLK_ON;
      ST_CLK_ON:    state_d = ST_FIN;
      ST_WAIT_LONG: if (expired) state_d = ST_CLK_OFF;
      ST_CLK_OFF:   state_d = ST_FIN;
      ST_FIN:       state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    step         = '0;
    step.sleep   = (state_q == ST_SLEEP);
    step.mem     = (state_q == ST_MEM);
    step.rst_set = (state_q == ST_RST_SET);
    step.iso     = (state_q == ST_ISO);
    step.rst_clr = (state_q == ST_RST_CLR);
    step.clk_on  = (state_q == ST_CLK_ON);
    step.clk_off = (state_q == ST_CLK_OFF);
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign err       = done & err_q;
  assign sel       = sel_q;
  assign on_dir    = on_q;

endmodule

// File: rtl/pwr_dom_seq_ctl.sv
module pwr_dom_seq_ctl
  import pwr_dom_seq_pkg::*;
#(
  parameter int               N_DOM   = 4,
  parameter int               FIELDS  = 2,
  parameter int               SEL_W   = 2,
  parameter logic [N_DOM-1:0] HAS_TOP = '1,
  parameter logic [N_DOM-1:0] HAS_RST = '1,
  parameter logic [N_DOM-1:0] HAS_CLK = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  step_t                     step,
  input  logic [SEL_W-1:0]          sel,
  input  logic                      on_dir,
  output logic [N_DOM-1:0]          sleep_o,
  output logic [N_DOM-1:0]          iso_o,
  output logic [N_DOM*2*FIELDS-1:0] mem_pd_o,
  output logic [N_DOM-1:0]          rst_o,
  output logic [N_DOM-1:0]          clk_en_o,
  output logic [N_DOM-1:0]          powered_o
);

  localparam int FW = 2 * FIELDS;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic          hit;
    logic          sleep_q;
    logic          iso_q;
    logic          rst_q;
    logic          clk_q;
    logic [FIELDS-1:0] fld_q;

    assign hit = (sel == SEL_W'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sleep_q <= 1'b1;
        iso_q   <= 1'b1;
        rst_q   <= 1'b1;
        clk_q   <= 1'b0;
        fld_q   <= '1;
      end else if (hit) begin
        if (step.sleep && HAS_TOP[d])   sleep_q <= ~on_dir;
        if (step.mem)                   fld_q   <= {FIELDS{~on_dir}};
        if (step.rst_set && HAS_RST[d]) rst_q   <= 1'b1;
        if (step.iso && HAS_TOP[d])     iso_q   <= ~on_dir;
        if (step.rst_clr && HAS_RST[d]) rst_q   <= 1'b0;
        if (step.clk_on && HAS_CLK[d])  clk_q   <= 1'b1;
        if (step.clk_off && HAS_CLK[d]) clk_q   <= 1'b0;
      end
    end

    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
      assign mem_pd_o[d*FW + 2*f]     = fld_q[f];
      assign mem_pd_o[d*FW + 2*f + 1] = fld_q[f];
    end

    assign sleep_o[d]  = sleep_q;
    assign iso_o[d]    = iso_q;
    assign rst_o[d]    = rst_q;
    assign clk_en_o[d] = clk_q;

    if (HAS_TOP[d]) begin : g_top
      assign powered_o[d] = ~sleep_q;
    end else begin : g_memonly
      assign powered_o[d] = ~|fld_q;
    end
  end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_seq_pkg::*;
#(
  parameter int               N_DOM      = 4,
  parameter int               FIELDS     = 2,
  parameter int               IDX_W      = 3,
  parameter int               CYC_PER_US = 100,
  parameter int               SHORT_US   = 20,
  parameter int               LONG_US    = 20000,
  parameter logic [N_DOM-1:0] HAS_TOP    = 4'b0111,
  parameter logic [N_DOM-1:0] HAS_RST    = 4'b0001,
  parameter logic [N_DOM-1:0] HAS_CLK    = 4'b0001
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [IDX_W-1:0]          req_dom_i,
  input  logic                      req_on_i,
  output logic                      done_o,
  output logic                      err_o,
  output logic [N_DOM-1:0]          sleep_o,
  output logic [N_DOM-1:0]          iso_o,
  output logic [N_DOM*2*FIELDS-1:0] mem_pd_o,
  output logic [N_DOM-1:0]          rst_o,
  output logic [N_DOM-1:0]          clk_en_o,
  output logic [N_DOM-1:0]          powered_o
);

  localparam int SEL_W     = (N_DOM > 1) ? $clog2(N_DOM) : 1;
  localparam int SHORT_CYC = CYC_PER_US * SHORT_US;
  localparam int LONG_CYC  = CYC_PER_US * LONG_US;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;
  step_t            step;
  logic [SEL_W-1:0] sel;
  logic             on_dir;

  pwr_dom_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  pwr_dom_seq_fsm #(
    .N_DOM     (N_DOM),
    .IDX_W     (IDX_W),
    .SEL_W     (SEL_W),
    .CNT_W     (CNT_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC),
    .HAS_CLK   (HAS_CLK)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid_i),
    .req_ready (req_ready_o),
    .req_dom   (req_dom_i),
    .req_on    (req_on_i),
    .expired   (t_expired),
    .t_load    (t_load),
    .t_val     (t_val),
    .step      (step),
    .sel       (sel),
    .on_dir    (on_dir),
    .done      (done_o),
    .err       (err_o)
  );

  pwr_dom_seq_ctl #(
    .N_DOM   (N_DOM),
    .FIELDS  (FIELDS),
    .SEL_W   (SEL_W),
    .HAS_TOP (HAS_TOP),
    .HAS_RST (HAS_RST),
    .HAS_CLK (HAS_CLK)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .sel       (sel),
    .on_dir    (on_dir),
    .sleep_o   (sleep_o),
    .iso_o     (iso_o),
    .mem_pd_o  (mem_pd_o),
    .rst_o     (rst_o),
    .clk_en_o  (clk_en_o),
    .powered_o (powered_o)
  );

endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk #(
  parameter int               N_DOM   = 4,
  parameter int               FIELDS  = 2,
  parameter logic [N_DOM-1:0] HAS_TOP = '1,
  parameter logic [N_DOM-1:0] HAS_RST = '1,
  parameter logic [N_DOM-1:0] HAS_CLK = '1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_ready_o,
  input logic                      done_o,
  input logic                      err_o,
  input logic [N_DOM-1:0]          sleep_o,
  input logic [N_DOM-1:0]          iso_o,
  input logic [N_DOM*2*FIELDS-1:0] mem_pd_o,
  input logic [N_DOM-1:0]          rst_o,
  input logic [N_DOM-1:0]          clk_en_o
);

  localparam int FW = 2 * FIELDS;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_ready_o); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R8

  for (genvar k = 0; k < N_DOM * FIELDS; k++) begin : g_pair
    AST_FIELD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_pd_o[2*k] == mem_pd_o[2*k+1]); // R6
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    if (HAS_TOP[d]) begin : g_top
      AST_ISO_OPEN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_o[d]) |-> (!sleep_o[d] && mem_pd_o[d*FW +: FW] == '0)); // R1
      AST_MEM_UP_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_pd_o[d*FW]) |-> !sleep_o[d]); // R1
      AST_ISO_CLOSE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_o[d]) |-> (sleep_o[d] && mem_pd_o[d*FW +: FW] == '1)); // R2
      AST_MEM_DOWN_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_pd_o[d*FW]) |-> sleep_o[d]); // R2
      AST_GATE_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o[d]) |-> iso_o[d]); // R3
      AST_CLK_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o[d]) |-> !iso_o[d]); // R1
    end else begin : g_memonly
      AST_MEMONLY_SWITCH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o[d] && iso_o[d]); // R4
    end
    if (HAS_RST[d]) begin : g_rst
      AST_CLK_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o[d]) |-> !rst_o[d]); // R1
    end else begin : g_norst
      AST_NO_RESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o[d]); // R5
    end
    if (!HAS_CLK[d]) begin : g_noclk
      AST_NO_CLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o[d]); // R5
    end
  end

endmodule

bind pwr_dom_seq pwr_dom_seq_chk #(
  .N_DOM   (N_DOM),
  .FIELDS  (FIELDS),
  .HAS_TOP (HAS_TOP),
  .HAS_RST (HAS_RST),
  .HAS_CLK (HAS_CLK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .sleep_o     (sleep_o),
  .iso_o       (iso_o),
  .mem_pd_o    (mem_pd_o),
  .rst_o       (rst_o),
  .clk_en_o    (clk_en_o)
);

// File: tb/pwr_dom_seq_bench.sv
`timescale 1ns/1ps
module pwr_dom_seq_bench;

  localparam int N       = 4;
  localparam int FIELDS  = 2;
  localparam int IDX_W   = 3;
  localparam int CPU     = 2;
  localparam int S_US    = 20;
  localparam int L_US    = 30;
  localparam int U       = CPU * S_US;
  localparam int L       = CPU * L_US;
  localparam int FW      = 2 * FIELDS;
  localparam int MW      = N * FW;
  localparam logic [N-1:0] TOP  = 4'b0111;
  localparam logic [N-1:0] RSTM = 4'b0011;
  localparam logic [N-1:0] CLKM = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IDX_W-1:0] req_dom = '0;
  logic req_on = 1'b0;
  logic done, err;
  logic [N-1:0]  sleep_v, iso_v, rst_v, clk_v, pwr_v;
  logic [MW-1:0] mem_v;

  always #2.5 clk = ~clk;

  pwr_dom_seq #(
    .N_DOM(N), .FIELDS(FIELDS), .IDX_W(IDX_W), .CYC_PER_US(CPU),
    .SHORT_US(S_US), .LONG_US(L_US), .HAS_TOP(TOP), .HAS_RST(RSTM), .HAS_CLK(CLKM)
  ) u_pwr_dom_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_dom_i(req_dom), .req_on_i(req_on), .done_o(done), .err_o(err),
    .sleep_o(sleep_v), .iso_o(iso_v), .mem_pd_o(mem_v), .rst_o(rst_v),
    .clk_en_o(clk_v), .powered_o(pwr_v)
  );

  int n_pass = 0;
  int n_tot  = 0;
  bit m_sleep[N], m_iso[N], m_rst[N], m_clk[N], m_mem[N];

  function automatic logic [N-1:0] pack(input bit a[N]);
    logic [N-1:0] v;
    for (int d = 0; d < N; d++) v[d] = a[d];
    return v;
  endfunction

  function automatic logic [MW-1:0] mem_exp();
    logic [MW-1:0] v;
    for (int d = 0; d < N; d++)
      for (int b = 0; b < FW; b++) v[d*FW+b] = m_mem[d];
    return v;
  endfunction

  function automatic logic [N-1:0] pwr_exp();
    logic [N-1:0] v;
    for (int d = 0; d < N; d++) v[d] = TOP[d] ? ~m_sleep[d] : ~m_mem[d];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic chk_all(input string tag);
    chk(sleep_v == pack(m_sleep), tag, "sleep", 64'(sleep_v), 64'(pack(m_sleep)));
    chk(iso_v == pack(m_iso), tag, "iso", 64'(iso_v), 64'(pack(m_iso)));
    chk(mem_v == mem_exp(), "R6", "mem", 64'(mem_v), 64'(mem_exp()));
    chk(rst_v == pack(m_rst), tag, "rst", 64'(rst_v), 64'(pack(m_rst)));
    chk(clk_v == pack(m_clk), tag, "clk_en", 64'(clk_v), 64'(pack(m_clk)));
    chk(pwr_v == pwr_exp(), "R7", "powered", 64'(pwr_v), 64'(pwr_exp()));
  endtask

  task automatic do_req(input int d, input bit on, input bit inject);
    logic [MW-1:0] mem_old;
    logic [N-1:0]  sleep_new;
    string tag;
    int n, lat, exp_lat;
    bit valid_dom;
    valid_dom = (d < N);
    mem_old = mem_v;
    if (!valid_dom)                   begin tag = "R8"; exp_lat = 0; end
    else if (on)                      begin tag = "R1"; exp_lat = 6 + 2*U; end
    else if (CLKM[d])                 begin tag = "R3"; exp_lat = 4 + 2*U + L; end
    else                              begin tag = "R2"; exp_lat = 3 + 2*U; end
    if (valid_dom) begin
      if (TOP[d]) begin m_sleep[d] = ~on; m_iso[d] = ~on; end
      m_mem[d] = ~on;
      if (RSTM[d] && on) m_rst[d] = 1'b0;
      if (CLKM[d]) m_clk[d] = on;
    end
    sleep_new = pack(m_sleep);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_dom = IDX_W'(d); req_on = on;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    n = 0; lat = -1;
    while (lat < 0 && n < 1000) begin
      if (done) lat = n;
      else begin
        if (inject && n == 4) begin req_valid = 1'b1; req_dom = IDX_W'(3); req_on = 1'b1; end
        if (inject && n == 5) req_valid = 1'b0;
        @(posedge clk); @(negedge clk); n++;
        if (valid_dom && n == 1)
          chk(sleep_v == sleep_new, tag, "sleep at +1", 64'(sleep_v), 64'(sleep_new));
        if (valid_dom && n == 1 + U)
          chk(mem_v == mem_old, tag, "mem held through wait", 64'(mem_v), 64'(mem_old));
        if (valid_dom && n == 2 + U)
          chk(mem_v == mem_exp(), tag, "mem at +2+U", 64'(mem_v), 64'(mem_exp()));
      end
    end
    chk(lat == exp_lat, tag, "done latency", 64'(lat), 64'(exp_lat));
    chk(err == !valid_dom, "R8", "err flag", 64'(err), 64'(!valid_dom));
    chk_all(tag);
    @(posedge clk); @(negedge clk);
    chk(!done && req_ready, "R9", "done one cycle then ready", 64'({done, req_ready}), 64'b01);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(req_ready && !done, "R9", "busy request ignored", 64'({req_ready, done}), 64'b10);
      chk_all("R9");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

  initial begin
    for (int d = 0; d < N; d++) begin
      m_sleep[d] = 1'b1; m_iso[d] = 1'b1; m_rst[d] = 1'b1; m_clk[d] = 1'b0; m_mem[d] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done, "R10", "ready after reset", 64'({req_ready, done}), 64'b10);
    chk_all("R10");

    for (int d = 0; d < N; d++) do_req(d, 1'b1, 1'b0);
    chk(sleep_v[3] && iso_v[3], "R4", "memory-only switch bits", 64'({sleep_v[3], iso_v[3]}), 64'b11);
    chk(pwr_v[3] == 1'b1, "R4", "memory-only powered", 64'(pwr_v[3]), 64'b1);
    chk(rst_v[2] == 1'b1, "R5", "no-reset domain", 64'(rst_v[2]), 64'b1);
    chk(clk_v[1] == 1'b0 && clk_v[3] == 1'b0, "R5", "no-clock domains",
        64'({clk_v[1], clk_v[3]}), 64'b0);

    for (int d = 0; d < N; d++) do_req(d, 1'b0, 1'b0);
    chk(pwr_v == '0, "R7", "all off", 64'(pwr_v), 64'b0);

    do_req(1, 1'b1, 1'b1);
    do_req(0, 1'b1, 1'b0);
    do_req(0, 1'b0, 1'b0);

    for (int d = N; d < (1 << IDX_W); d++) do_req(d, 1'b1, 1'b0);
    do_req(N, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

endmodule